// File: doc/BRIEF.md
# Standby Clock-Gating Controller

This block decides when a small microcontroller enters and leaves its low-power idle state. It also sets which clocks keep running while the chip is idle. Software writes one byte to a standby command register. Two bits of that byte select a standby mode: a stop-request bit and a halt-request bit. When both are set and no interrupt is pending, the controller moves to IDLE. In IDLE the oscillator keeps running, the CPU clock stops, and each peripheral follows its own idle policy. An unmasked interrupt request brings the controller back to RUN one clock edge later.

The controller runs on the free-running oscillator clock. It is a four-state machine with the states RUN, HALT, STOP and IDLE. Only IDLE changes the clock policy. HALT and STOP are decoded and shown on the mode output, but the clocks stay as they are in RUN. The transitions are:
- RUN_TO_MODE: a write from RUN with no interrupt pending goes to the decoded mode.
- REFUSE: a standby write made while an interrupt is pending keeps the controller in RUN.
- WAKE: HALT, STOP or IDLE returns to RUN when an interrupt is pending.
- HOLD: every other cycle keeps the current state.

In IDLE the peripheral policy is:
- The watchdog clock is off and its clear is held asserted.
- The watch timer and the external interrupt inputs keep running.
- The PWM timer runs only if its external count clock is selected.
- The 16-bit timer, the A/D converter and the serial interfaces are stopped.
- The serial receive inputs are forced low.

Top module: `stby_ctl`

## Requirements
- R1: After reset the controller is in RUN (mode_o = 2'b00). All clock enables are 1, wdt_clr is 0, and ser_rx_o equals ser_rx_i.
- R2: In RUN, a write (wr_en = 1) with bit 1 (stop request) and bit 0 (halt request) both set, made while irq_pend = 0, gives mode_o = 2'b11 (IDLE) after that clock edge. Bits 7 down to 2 have no effect.
- R3: In RUN, a write that requests HALT, STOP or IDLE while irq_pend = 1 leaves the controller in RUN with cpu_clk_en = 1.
- R4: In IDLE, cpu_clk_en is 0 and osc_en is 1.
- R5: In IDLE, wdt_clk_en is 0 and wdt_clr is 1.
- R6: In IDLE, watch_clk_en is 1 and all bits of extint_en are 1.
- R7: In IDLE, pwm_clk_en follows pwm_ext_sel (1 means the external count clock is selected).
- R8: In IDLE, tmr16_clk_en, adc_clk_en and all bits of ser_clk_en are 0, and ser_rx_o is all zeros whatever ser_rx_i is. Outside IDLE, ser_rx_o equals ser_rx_i.
- R9: In IDLE, irq_pend = 1 at a clock edge returns the controller to RUN at that edge. The CPU and peripheral clocks are enabled again and wdt_clr is released.
- R10: In RUN, a write with only bit 0 set gives mode_o = 2'b01 (HALT), and a write with only bit 1 set gives mode_o = 2'b10 (STOP). In both states all clock enables stay 1. Both states return to RUN on irq_pend = 1.
- R11: Writes made in HALT, STOP or IDLE are ignored. The mode does not change.
- R12: In RUN, a write with bits 1 and 0 both clear keeps the controller in RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Free-running oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Standby command register write strobe |
| wr_data | input | 8 | Byte written to the command register |
| irq_pend | input | 1 | An unmasked interrupt request is pending |
| pwm_ext_sel | input | 1 | PWM timer counts from an external clock |
| ser_rx_i | input | 2 | Raw serial receive inputs |
| mode_o | output | 2 | Current mode: 00 RUN, 01 HALT, 10 STOP, 11 IDLE |
| osc_en | output | 1 | Oscillator enable |
| cpu_clk_en | output | 1 | CPU system clock enable |
| wdt_clk_en | output | 1 | Watchdog clock enable |
| wdt_clr | output | 1 | Watchdog hold-clear |
| watch_clk_en | output | 1 | Watch timer clock enable |
| extint_en | output | 3 | External interrupt input enables |
| pwm_clk_en | output | 1 | PWM timer count clock enable |
| tmr16_clk_en | output | 1 | 16-bit timer clock enable |
| adc_clk_en | output | 1 | A/D converter clock enable |
| ser_clk_en | output | 2 | Serial interface clock enables |
| ser_rx_o | output | 2 | Gated serial receive inputs |

## Verification
The bench writes an idle request while an interrupt is already pending. A design that does not refuse this write would stop the CPU clock with nothing left to wake it in time. The bench writes all ones to check that bits 7 to 2 are ignored; a decoder that looks at the whole byte would not enter IDLE. It also writes during HALT, STOP and IDLE, and a design that accepted those writes would change mode with no interrupt. The bench toggles the PWM clock select and the serial inputs during IDLE. It then places the wake interrupt just before a clock edge, which exposes a wrong policy, a stuck output or an extra cycle of wake latency.

// File: rtl/stby_pkg.sv
package stby_pkg;

    // Mode code: bit 1 is the stop request, bit 0 is the halt request
    typedef enum logic [1:0] {
        M_RUN  = 2'b00,
        M_HALT = 2'b01,
        M_STOP = 2'b10,
        M_IDLE = 2'b11
    } stby_mode_e;

endpackage

// File: rtl/stby_req_decode.sv
module stby_req_decode
    import stby_pkg::*;
#(
    parameter int CTRL_W  = 8,
    parameter int STP_BIT = 1,
    parameter int HLT_BIT = 0
) (
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic              req_valid,
    output stby_mode_e        req_mode
);

    // Only the two request bits matter; the rest of the byte is ignored
    logic unused_bits;
    assign unused_bits = ^wr_data;

    assign req_valid = wr_en;

    always_comb begin
        req_mode = stby_mode_e'({wr_data[STP_BIT], wr_data[HLT_BIT]});
    end

endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
    import stby_pkg::*;
(
    input  logic       clk_osc,
    input  logic       rst_n,
    input  logic       req_valid,
    input  stby_mode_e req_mode,
    input  logic       irq_pend,
    output stby_mode_e state_q
);

    stby_mode_e state_d;

    // State register
    always_ff @(posedge clk_osc or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= M_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            M_RUN: begin
                if (req_valid) begin
                    // REFUSE: a pending release keeps the CPU clock running
                    if (req_mode != M_RUN && irq_pend) begin
                        state_d = M_RUN;
                    end else begin
                        state_d = req_mode; // RUN_TO_MODE
                    end
                end
            end
            M_HALT, M_STOP, M_IDLE: begin
                // WAKE on a pending request; writes are ignored here
                if (irq_pend) begin
                    state_d = M_RUN;
                end
            end
            default: state_d = M_RUN;
        endcase
    end

endmodule

// File: rtl/stby_clk_policy.sv
module stby_clk_policy
    import stby_pkg::*;
#(
    parameter int NUM_EXTINT = 3,
    parameter int NUM_SER    = 2
) (
    input  stby_mode_e            state_q,
    input  logic                  pwm_ext_sel,
    output logic                  osc_en,
    output logic                  cpu_clk_en,
    output logic                  wdt_clk_en,
    output logic                  wdt_clr,
    output logic                  watch_clk_en,
    output logic [NUM_EXTINT-1:0] extint_en,
    output logic                  pwm_clk_en,
    output logic                  tmr16_clk_en,
    output logic                  adc_clk_en,
    output logic [NUM_SER-1:0]    ser_clk_en,
    output logic                  rx_gate
);

    localparam logic [NUM_EXTINT-1:0] EXT_ALL = {NUM_EXTINT{1'b1}};
    localparam logic [NUM_SER-1:0]    SER_ALL = {NUM_SER{1'b1}};

    always_comb begin
        osc_en       = 1'b1;
        cpu_clk_en   = 1'b1;
        wdt_clk_en   = 1'b1;
        wdt_clr      = 1'b0;
        watch_clk_en = 1'b1;
        extint_en    = EXT_ALL;
        pwm_clk_en   = 1'b1;
        tmr16_clk_en = 1'b1;
        adc_clk_en   = 1'b1;
        ser_clk_en   = SER_ALL;
        rx_gate      = 1'b0;
        unique case (state_q)
            M_RUN, M_HALT, M_STOP: begin
                // run-mode clock policy; other standby states are not modelled
            end
            M_IDLE: begin
                cpu_clk_en   = 1'b0;
                wdt_clk_en   = 1'b0;
                wdt_clr      = 1'b1;
                pwm_clk_en   = pwm_ext_sel;
                tmr16_clk_en = 1'b0;
                adc_clk_en   = 1'b0;
                ser_clk_en   = '0;
                rx_gate      = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/stby_rx_gate.sv
module stby_rx_gate #(
    parameter int NUM_SER = 2
) (
    input  logic               rx_gate,
    input  logic [NUM_SER-1:0] ser_rx_i,
    output logic [NUM_SER-1:0] ser_rx_o
);

    for (genvar g = 0; g < NUM_SER; g++) begin : g_ch
        assign ser_rx_o[g] = rx_gate ? 1'b0 : ser_rx_i[g];
    end

endmodule

// File: rtl/stby_ctl.sv
module stby_ctl
    import stby_pkg::*;
#(
    parameter int CTRL_W     = 8,
    parameter int STP_BIT    = 1,
    parameter int HLT_BIT    = 0,
    parameter int NUM_EXTINT = 3,
    parameter int NUM_SER    = 2
) (
    input  logic                  clk_osc,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [CTRL_W-1:0]     wr_data,
    input  logic                  irq_pend,
    input  logic                  pwm_ext_sel,
    input  logic [NUM_SER-1:0]    ser_rx_i,
    output logic [1:0]            mode_o,
    output logic                  osc_en,
    output logic                  cpu_clk_en,
    output logic                  wdt_clk_en,
    output logic                  wdt_clr,
    output logic                  watch_clk_en,
    output logic [NUM_EXTINT-1:0] extint_en,
    output logic                  pwm_clk_en,
    output logic                  tmr16_clk_en,
    output logic                  adc_clk_en,
    output logic [NUM_SER-1:0]    ser_clk_en,
    output logic [NUM_SER-1:0]    ser_rx_o
);

    logic       req_valid;
    stby_mode_e req_mode;
    stby_mode_e state_q;
    logic       rx_gate;

    stby_req_decode #(
        .CTRL_W (CTRL_W),
        .STP_BIT(STP_BIT),
        .HLT_BIT(HLT_BIT)
    ) u_dec (
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .req_valid(req_valid),
        .req_mode (req_mode)
    );

    stby_fsm u_fsm (
        .clk_osc  (clk_osc),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_mode (req_mode),
        .irq_pend (irq_pend),
        .state_q  (state_q)
    );

    stby_clk_policy #(
        .NUM_EXTINT(NUM_EXTINT),
        .NUM_SER   (NUM_SER)
    ) u_pol (
        .state_q     (state_q),
        .pwm_ext_sel (pwm_ext_sel),
        .osc_en      (osc_en),
        .cpu_clk_en  (cpu_clk_en),
        .wdt_clk_en  (wdt_clk_en),
        .wdt_clr     (wdt_clr),
        .watch_clk_en(watch_clk_en),
        .extint_en   (extint_en),
        .pwm_clk_en  (pwm_clk_en),
        .tmr16_clk_en(tmr16_clk_en),
        .adc_clk_en  (adc_clk_en),
        .ser_clk_en  (ser_clk_en),
        .rx_gate     (rx_gate)
    );

    stby_rx_gate #(
        .NUM_SER(NUM_SER)
    ) u_rx (
        .rx_gate (rx_gate),
        .ser_rx_i(ser_rx_i),
        .ser_rx_o(ser_rx_o)
    );

    assign mode_o = state_q;

endmodule

// File: rtl/stby_ctl_chk.sv
module stby_ctl_chk #(
    parameter int CTRL_W     = 8,
    parameter int STP_BIT    = 1,
    parameter int HLT_BIT    = 0,
    parameter int NUM_EXTINT = 3,
    parameter int NUM_SER    = 2
) (
    input logic                  clk_osc,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic [CTRL_W-1:0]     wr_data,
    input logic                  irq_pend,
    input logic                  pwm_ext_sel,
    input logic [1:0]            mode_o,
    input logic                  osc_en,
    input logic                  cpu_clk_en,
    input logic                  wdt_clk_en,
    input logic                  wdt_clr,
    input logic                  watch_clk_en,
    input logic [NUM_EXTINT-1:0] extint_en,
    input logic                  pwm_clk_en,
    input logic                  tmr16_clk_en,
    input logic                  adc_clk_en,
    input logic [NUM_SER-1:0]    ser_clk_en,
    input logic [NUM_SER-1:0]    ser_rx_o
);

    logic unused_wr;
    assign unused_wr = ^wr_data;

    logic idle_now;
    logic idle_req;
    assign idle_now = (mode_o == 2'b11);
    assign idle_req = wr_data[STP_BIT] && wr_data[HLT_BIT];

    AST_IDLE_ENTRY: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (mode_o == 2'b00 && wr_en && idle_req && !irq_pend) |=> idle_now); // R2
    AST_REFUSE_PENDING: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (mode_o == 2'b00 && wr_en && irq_pend) |=> (mode_o == 2'b00)); // R3
    AST_CPU_STOPPED: assert property (@(posedge clk_osc) disable iff (!rst_n)
        idle_now |-> (!cpu_clk_en && osc_en)); // R4
    AST_WDT_HELD: assert property (@(posedge clk_osc) disable iff (!rst_n)
        idle_now |-> (!wdt_clk_en && wdt_clr)); // R5
    AST_WAKE_SOURCES_LIVE: assert property (@(posedge clk_osc) disable iff (!rst_n)
        idle_now |-> (watch_clk_en && (&extint_en))); // R6
    AST_PWM_FOLLOWS_SEL: assert property (@(posedge clk_osc) disable iff (!rst_n)
        idle_now |-> (pwm_clk_en == pwm_ext_sel)); // R7
    AST_SER_QUIET: assert property (@(posedge clk_osc) disable iff (!rst_n)
        idle_now |-> (ser_rx_o == '0 && ser_clk_en == '0 && !tmr16_clk_en && !adc_clk_en)); // R8
    AST_WAKE_NEXT: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (idle_now && irq_pend) |=> (mode_o == 2'b00 && cpu_clk_en && !wdt_clr)); // R9
    AST_STANDBY_HOLD: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (mode_o != 2'b00 && !irq_pend) |=> $stable(mode_o)); // R11

endmodule

bind stby_ctl stby_ctl_chk #(
    .CTRL_W    (CTRL_W),
    .STP_BIT   (STP_BIT),
    .HLT_BIT   (HLT_BIT),
    .NUM_EXTINT(NUM_EXTINT),
    .NUM_SER   (NUM_SER)
) u_chk (.*);

// File: tb/tb_stby_ctl.sv
module tb_stby_ctl;

    localparam int CLK_P = 10;
    localparam int WD_CYCLES = 5000;

    logic       clk_osc = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [7:0] wr_data;
    logic       irq_pend;
    logic       pwm_ext_sel;
    logic [1:0] ser_rx_i;
    logic [1:0] mode_o;
    logic       osc_en, cpu_clk_en, wdt_clk_en, wdt_clr, watch_clk_en;
    logic [2:0] extint_en;
    logic       pwm_clk_en, tmr16_clk_en, adc_clk_en;
    logic [1:0] ser_clk_en;
    logic [1:0] ser_rx_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_P/2) clk_osc = ~clk_osc;

    stby_ctl dut (
        .clk_osc(clk_osc), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .irq_pend(irq_pend), .pwm_ext_sel(pwm_ext_sel), .ser_rx_i(ser_rx_i),
        .mode_o(mode_o), .osc_en(osc_en), .cpu_clk_en(cpu_clk_en),
        .wdt_clk_en(wdt_clk_en), .wdt_clr(wdt_clr), .watch_clk_en(watch_clk_en),
        .extint_en(extint_en), .pwm_clk_en(pwm_clk_en), .tmr16_clk_en(tmr16_clk_en),
        .adc_clk_en(adc_clk_en), .ser_clk_en(ser_clk_en), .ser_rx_o(ser_rx_o)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // full run-mode picture: every enable on, no clear, inputs pass
    task automatic chk_run_outputs(input string req);
        chk(req, "mode", {30'd0, mode_o}, 32'd0);
        chk(req, "cpu_clk_en", {31'd0, cpu_clk_en}, 32'd1);
        chk(req, "wdt", {30'd0, wdt_clk_en, wdt_clr}, 32'b10);
        chk(req, "others", {24'd0, watch_clk_en, extint_en, pwm_clk_en, tmr16_clk_en, adc_clk_en, osc_en},
            32'hFF);
        chk(req, "ser_clk_en", {30'd0, ser_clk_en}, 32'd3);
        chk(req, "ser_rx_o", {30'd0, ser_rx_o}, {30'd0, ser_rx_i});
    endtask

    // one-cycle write, sampled on the falling edge after the capturing edge
    task automatic wr_byte(input logic [7:0] d, input logic irq);
        @(negedge clk_osc);
        wr_en = 1'b1; wr_data = d; irq_pend = irq;
        @(negedge clk_osc);
        wr_en = 1'b0; irq_pend = 1'b0;
    endtask

    task automatic wake();
        @(negedge clk_osc);
        irq_pend = 1'b1;
        @(negedge clk_osc);
        irq_pend = 1'b0;
    endtask

    task automatic t_reset();
        ser_rx_i = 2'b10;
        @(negedge clk_osc);
        chk_run_outputs("R1");
    endtask

    task automatic t_idle_policy();
        wr_byte(8'h03, 1'b0);
        chk("R2", "enter idle", {30'd0, mode_o}, 32'd3);
        chk("R4", "cpu/osc", {30'd0, cpu_clk_en, osc_en}, 32'b01);
        chk("R5", "wdt en/clr", {30'd0, wdt_clk_en, wdt_clr}, 32'b01);
        chk("R6", "watch/extint", {28'd0, watch_clk_en, extint_en}, 32'hF);
        pwm_ext_sel = 1'b0; #1;
        chk("R7", "pwm internal", {31'd0, pwm_clk_en}, 32'd0);
        pwm_ext_sel = 1'b1; #1;
        chk("R7", "pwm external", {31'd0, pwm_clk_en}, 32'd1);
        ser_rx_i = 2'b11; #1;
        chk("R8", "rx forced low", {30'd0, ser_rx_o}, 32'd0);
        chk("R8", "stopped clocks", {28'd0, tmr16_clk_en, adc_clk_en, ser_clk_en}, 32'd0);
        wr_byte(8'h00, 1'b0);
        chk("R11", "write in idle", {30'd0, mode_o}, 32'd3);
        // wake timing: pending just before an edge
        @(negedge clk_osc);
        irq_pend = 1'b1; #1;
        chk("R9", "still idle before edge", {30'd0, mode_o}, 32'd3);
        @(negedge clk_osc);
        irq_pend = 1'b0;
        chk_run_outputs("R9");
        pwm_ext_sel = 1'b0;
    endtask

    task automatic t_upper_bits();
        wr_byte(8'hFF, 1'b0);
        chk("R2", "upper bits ignored", {30'd0, mode_o}, 32'd3);
        wake();
        chk("R9", "wake after FF", {30'd0, mode_o}, 32'd0);
    endtask

    task automatic t_refuse();
        wr_byte(8'h03, 1'b1);
        chk("R3", "refused idle", {30'd0, mode_o}, 32'd0);
        chk("R3", "cpu runs", {31'd0, cpu_clk_en}, 32'd1);
        wr_byte(8'h01, 1'b1);
        chk("R3", "refused halt", {30'd0, mode_o}, 32'd0);
    endtask

    task automatic t_halt_stop();
        wr_byte(8'h01, 1'b0);
        chk("R10", "halt code", {30'd0, mode_o}, 32'd1);
        chk("R10", "halt clocks", {29'd0, cpu_clk_en, wdt_clk_en, tmr16_clk_en}, 32'd7);
        wake();
        chk("R10", "halt wake", {30'd0, mode_o}, 32'd0);
        wr_byte(8'h02, 1'b0);
        chk("R10", "stop code", {30'd0, mode_o}, 32'd2);
        chk("R10", "stop rx pass", {30'd0, ser_rx_o}, {30'd0, ser_rx_i});
        wr_byte(8'h03, 1'b0);
        chk("R11", "write in stop", {30'd0, mode_o}, 32'd2);
        wake();
        chk("R10", "stop wake", {30'd0, mode_o}, 32'd0);
    endtask

    task automatic t_run_writes();
        wr_byte(8'h00, 1'b0);
        chk("R12", "write 00", {30'd0, mode_o}, 32'd0);
        wr_byte(8'hFC, 1'b0);
        chk("R12", "write FC", {30'd0, mode_o}, 32'd0);
        chk_run_outputs("R12");
    endtask

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00; irq_pend = 1'b0;
        pwm_ext_sel = 1'b0; ser_rx_i = 2'b00;
        repeat (3) @(negedge clk_osc);
        rst_n = 1'b1;
        t_reset();
        t_idle_policy();
        t_upper_bits();
        t_refuse();
        t_halt_stop();
        t_run_writes();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk_osc);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule